// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Responder for a Priority Chain

This block collects interrupt requests from several internal sources of one peripheral and answers the processor's vectored acknowledge cycle. Each source has its own 8-bit vector and its own enable. Every enabled pending request pulls the shared active-low request line. The block can work alone, with its chain-enable input tied low, or as one link in a priority chain, where its chain-enable output feeds the next lower-priority device.

When the shared acknowledge strobe falls, the block freezes its enabled pending set and picks a winner. Source 0 has the highest priority. If the incoming chain enable is low and something is frozen, the block answers the cycle. It drives the winner's vector and pulls the acknowledge handshake low, and it releases the request line while it does so. If the block has nothing frozen, it passes priority downstream by driving its chain-enable output low. When the strobe rises, the block clears the serviced source. It drives the handshake high for one cycle and then releases it. If other requests remain, it raises its request again. All inputs are sampled on `clk`.

Top module: `daisy_iack_responder`

## Requirements
- R1: After reset the request output, the chain-enable output and the handshake are high, and neither the vector bus nor the handshake is driven (`vec_oe_o` = 0, `dtack_oe_o` = 0).
- R2: A source whose `src_req_i` bit is high at a clock edge becomes pending. From that edge on, `intr_n_o` is low while the source's `src_en_i` bit is 1, whatever the level of `iei_n_i`. A disabled source stays pending and asserts `intr_n_o` once it is enabled.
- R3: At the first edge that sees `iack_n_i` low, the enabled pending set is frozen. A request that arrives later is latched but is not served in the current acknowledge.
- R4: When the set is frozen, non-empty and `iei_n_i` is low, the block answers at the next edge. It sets `vec_oe_o` = 1, `dtack_oe_o` = 1 and `dtack_n_o` = 0, places the winner's vector on `vec_o`, and holds `intr_n_o` high while it answers.
- R5: The lowest-numbered frozen source wins. A source's vector is bits [8i+7:8i] of `src_vec_i`.
- R6: `ieo_n_o` is low only while an acknowledge is frozen with an empty set and both `iack_n_i` and `iei_n_i` are low. It goes high at once when either of those inputs is high.
- R7: While the block answers, `ieo_n_o` stays high.
- R8: If the frozen set is empty, or `iei_n_i` stays high, the block does not drive the vector bus or the handshake during that acknowledge.
- R9: At the first edge after an answer that sees `iack_n_i` high, `vec_oe_o` falls and the handshake is driven high (`dtack_n_o` = 1, `dtack_oe_o` = 1) for one cycle. After that cycle `dtack_oe_o` = 0.
- R10: The served source's pending bit is cleared when the answer ends. After the release cycle, `intr_n_o` is low again if other enabled requests remain. Repeated acknowledges serve the sources in priority order until none is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | N_SRC | Request strobe, one bit per source |
| src_en_i | input | N_SRC | Enable, one bit per source |
| src_vec_i | input | N_SRC*VEC_W | Vector of each source, concatenated |
| iei_n_i | input | 1 | Chain enable from the higher-priority device, active low |
| iack_n_i | input | 1 | Shared acknowledge strobe, active low |
| intr_n_o | output | 1 | Interrupt request, active low |
| ieo_n_o | output | 1 | Chain enable to the lower-priority device, active low |
| vec_o | output | VEC_W | Vector value |
| vec_oe_o | output | 1 | Vector bus drive enable |
| dtack_n_o | output | 1 | Acknowledge handshake value, active low |
| dtack_oe_o | output | 1 | Handshake drive enable |

## Verification
A wrong pending bit shows on `intr_n_o` in the cycle after the edge that set or cleared it. A frozen set that drifts or picks the wrong winner shows as a wrong `vec_o` two edges after the strobe falls. A frozen set that wrongly looks empty or non-empty shows on `ieo_n_o` one edge after the fall, before any vector appears. A stuck answer state shows as a handshake that is still driven two edges after the strobe rises.

// File: rtl/daisy_iack_pkg.sv
package daisy_iack_pkg;

   // acknowledge sequencing states
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_FROZEN  = 2'd1,
      ST_ANSWER  = 2'd2,
      ST_RELEASE = 2'd3
   } ack_state_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/daisy_pend_bank.sv
module daisy_pend_bank #(
   parameter int unsigned N_SRC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] pend_o
);

   logic [N_SRC-1:0] pend_q;

   for (genvar i = 0; i < N_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           pend_q[i] <= 1'b0;
         else if (set_i[i])    pend_q[i] <= 1'b1;
         else if (clr_i[i])    pend_q[i] <= 1'b0;
      end

      // R10
      pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !pend_q[i]);

      // R2
      pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> pend_q[i]);
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/daisy_prio_pick.sv
module daisy_prio_pick #(
   parameter int unsigned N_SRC     = 4,
   parameter bit          LOW_WINS  = 1'b1,
   localparam int unsigned IDX_W    = daisy_iack_pkg::idx_width(N_SRC)
) (
   input  logic [N_SRC-1:0] req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [N_SRC-1:0] onehot_o
);

   assign any_o = |req_i;

   if (LOW_WINS) begin : g_low
      always_comb begin
         idx_o = '0;
         for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
         end
      end
   end else begin : g_high
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < N_SRC; i++) begin
            if (req_i[i]) idx_o = IDX_W'(i);
         end
      end
   end

   always_comb begin
      onehot_o = '0;
      if (any_o) onehot_o[idx_o] = 1'b1;
   end

endmodule

// File: rtl/daisy_ack_fsm.sv
module daisy_ack_fsm
   import daisy_iack_pkg::*;
#(
   parameter int unsigned N_SRC    = 4,
   parameter int unsigned VEC_W    = 8,
   parameter bit          LOW_WINS = 1'b1,
   localparam int unsigned IDX_W   = idx_width(N_SRC)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   iack_n_i,
   input  logic                   iei_n_i,
   input  logic [N_SRC-1:0]       live_i,
   input  logic [N_SRC*VEC_W-1:0] vec_flat_i,
   output logic [N_SRC-1:0]       clr_o,
   output logic                   busy_o,
   output logic                   ieo_n_o,
   output logic [VEC_W-1:0]       vec_o,
   output logic                   vec_oe_o,
   output logic                   dtack_n_o,
   output logic                   dtack_oe_o
);

   ack_state_e       state_q;
   logic [N_SRC-1:0] frozen_q;
   logic [N_SRC-1:0] win_q;
   logic [VEC_W-1:0] vec_q;

   logic             frz_any;
   logic [IDX_W-1:0] frz_idx;
   logic [N_SRC-1:0] frz_onehot;

   daisy_prio_pick #(
      .N_SRC    (N_SRC),
      .LOW_WINS (LOW_WINS)
   ) pick_i (
      .req_i    (frozen_q),
      .any_o    (frz_any),
      .idx_o    (frz_idx),
      .onehot_o (frz_onehot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         frozen_q <= '0;
         win_q    <= '0;
         vec_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (!iack_n_i) begin
                  frozen_q <= live_i;
                  state_q  <= ST_FROZEN;
               end
            end
            ST_FROZEN: begin
               if (iack_n_i) begin
                  frozen_q <= '0;
                  state_q  <= ST_IDLE;
               end else if (!iei_n_i && frz_any) begin
                  win_q   <= frz_onehot;
                  vec_q   <= vec_flat_i[frz_idx*VEC_W +: VEC_W];
                  state_q <= ST_ANSWER;
               end
            end
            ST_ANSWER: begin
               if (iack_n_i) begin
                  frozen_q <= '0;
                  state_q  <= ST_RELEASE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign clr_o      = (state_q == ST_ANSWER && iack_n_i) ? win_q : '0;
   assign busy_o     = (state_q == ST_ANSWER) || (state_q == ST_RELEASE);
   assign vec_oe_o   = (state_q == ST_ANSWER);
   assign vec_o      = vec_q;
   assign dtack_oe_o = busy_o;
   assign dtack_n_o  = (state_q != ST_ANSWER);
   assign ieo_n_o    = iack_n_i | iei_n_i | (state_q != ST_FROZEN) | frz_any;

   // R3
   frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FROZEN && $past(state_q) == ST_FROZEN) |-> $stable(frozen_q));

   // R5
   win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ANSWER) |-> $onehot0(win_q));

   // R9
   release_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RELEASE) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/daisy_iack_responder.sv
module daisy_iack_responder #(
   parameter int unsigned N_SRC    = 4,
   parameter int unsigned VEC_W    = 8,
   parameter bit          LOW_WINS = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_SRC-1:0]       src_req_i,
   input  logic [N_SRC-1:0]       src_en_i,
   input  logic [N_SRC*VEC_W-1:0] src_vec_i,
   input  logic                   iei_n_i,
   input  logic                   iack_n_i,
   output logic                   intr_n_o,
   output logic                   ieo_n_o,
   output logic [VEC_W-1:0]       vec_o,
   output logic                   vec_oe_o,
   output logic                   dtack_n_o,
   output logic                   dtack_oe_o
);

   if (N_SRC < 1 || N_SRC > 64) begin : g_bad_nsrc
      $error("daisy_iack_responder: N_SRC must be 1..64");
   end
   if (VEC_W < 1) begin : g_bad_vecw
      $error("daisy_iack_responder: VEC_W must be positive");
   end

   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] live;
   logic [N_SRC-1:0] clr;
   logic             busy;

   daisy_pend_bank #(
      .N_SRC (N_SRC)
   ) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (src_req_i),
      .clr_i  (clr),
      .pend_o (pend)
   );

   assign live = pend & src_en_i;

   daisy_ack_fsm #(
      .N_SRC    (N_SRC),
      .VEC_W    (VEC_W),
      .LOW_WINS (LOW_WINS)
   ) fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .iack_n_i   (iack_n_i),
      .iei_n_i    (iei_n_i),
      .live_i     (live),
      .vec_flat_i (src_vec_i),
      .clr_o      (clr),
      .busy_o     (busy),
      .ieo_n_o    (ieo_n_o),
      .vec_o      (vec_o),
      .vec_oe_o   (vec_oe_o),
      .dtack_n_o  (dtack_n_o),
      .dtack_oe_o (dtack_oe_o)
   );

   assign intr_n_o = ~(|live) | busy;

   // R4
   answer_drops_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe_o |-> intr_n_o);

   // R7
   answer_keeps_ieo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe_o |-> ieo_n_o);

   // R6
   ieo_low_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ieo_n_o |-> (!iack_n_i && !iei_n_i && !dtack_oe_o && $past(!iack_n_i)));

   // R9
   release_drive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(vec_oe_o) && !vec_oe_o) |-> (dtack_oe_o && dtack_n_o));

endmodule

// File: tb/daisy_iack_responder_tb.sv
module daisy_iack_responder_tb_top;

   localparam int N  = 4;
   localparam int VW = 8;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [N-1:0]    src_req;
   logic [N-1:0]    src_en;
   logic [N*VW-1:0] src_vec;
   logic            iei_n;
   logic            iack_n;
   logic            intr_n, ieo_n, vec_oe, dtack_n, dtack_oe;
   logic [VW-1:0]   vec;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   daisy_iack_responder #(.N_SRC(N), .VEC_W(VW)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_req_i  (src_req),
      .src_en_i   (src_en),
      .src_vec_i  (src_vec),
      .iei_n_i    (iei_n),
      .iack_n_i   (iack_n),
      .intr_n_o   (intr_n),
      .ieo_n_o    (ieo_n),
      .vec_o      (vec),
      .vec_oe_o   (vec_oe),
      .dtack_n_o  (dtack_n),
      .dtack_oe_o (dtack_oe)
   );

   function automatic logic [VW-1:0] vec_of(input int i);
      return VW'(8'h3C ^ (i * 8'h51));
   endfunction

   // fields: [11:8] request, [7:4] enable, [3] iei_n, [2] answers, [1:0] winner
   localparam logic [11:0] TBL [6] = '{
      {4'b0001, 4'b1111, 1'b0, 1'b1, 2'd0},
      {4'b1010, 4'b1111, 1'b0, 1'b1, 2'd1},
      {4'b1100, 4'b1111, 1'b0, 1'b1, 2'd2},
      {4'b0101, 4'b1110, 1'b0, 1'b1, 2'd2},
      {4'b1000, 4'b1111, 1'b1, 1'b0, 2'd0},
      {4'b0000, 4'b1111, 1'b0, 1'b0, 2'd0}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n   = 1'b0;
      src_req = '0;
      iack_n  = 1'b1;
      iei_n   = 1'b0;
      step();
      step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic pulse_req(input logic [N-1:0] m);
      src_req = m;
      step();
      src_req = '0;
   endtask

   // full acknowledge that is expected to be answered with vector of source w
   task automatic served_ack(input string req, input int w);
      iack_n = 1'b0;
      step();
      step();
      chk(req, "dtack_n", 32'(dtack_n), 32'd0);
      chk(req, "vec", 32'(vec), 32'(vec_of(w)));
      iack_n = 1'b1;
      step();
      step();
   endtask

   initial begin
      for (int i = 0; i < N; i++) src_vec[i*VW +: VW] = vec_of(i);
      src_en = '1;
      do_reset();

      // R1 reset state
      chk("R1", "intr_n", 32'(intr_n), 32'd1);
      chk("R1", "ieo_n", 32'(ieo_n), 32'd1);
      chk("R1", "dtack_oe", 32'(dtack_oe), 32'd0);
      chk("R1", "vec_oe", 32'(vec_oe), 32'd0);
      chk("R1", "dtack_n", 32'(dtack_n), 32'd1);

      // table walk: R2 R4 R5 R6 R8 R10
      for (int t = 0; t < 6; t++) begin
         logic [N-1:0] rq, en, rem;
         logic         ie, ans;
         int           w;
         rq  = TBL[t][11:8];
         en  = TBL[t][7:4];
         ie  = TBL[t][3];
         ans = TBL[t][2];
         w   = int'(TBL[t][1:0]);
         do_reset();
         src_en = en;
         iei_n  = ie;
         pulse_req(rq);
         chk("R2", "intr_n after request", 32'(intr_n), 32'((rq & en) == '0));
         iack_n = 1'b0;
         step();
         chk("R6", "ieo_n while frozen", 32'(ieo_n), 32'(!(ie == 1'b0 && (rq & en) == '0)));
         step();
         chk("R4", "vec_oe", 32'(vec_oe), 32'(ans));
         chk("R8", "dtack_oe", 32'(dtack_oe), 32'(ans));
         if (ans) begin
            chk("R5", "winner vector", 32'(vec), 32'(vec_of(w)));
            chk("R4", "intr_n released", 32'(intr_n), 32'd1);
            chk("R7", "ieo_n while answering", 32'(ieo_n), 32'd1);
         end
         iack_n = 1'b1;
         step();
         step();
         rem = ans ? ((rq & en) & ~(N'(1) << w)) : (rq & en);
         chk("R10", "intr_n after ack", 32'(intr_n), 32'(rem == '0));
      end
      src_en = '1;
      iei_n  = 1'b0;

      // R9 release timing
      do_reset();
      pulse_req(4'b0010);
      iack_n = 1'b0;
      step();
      step();
      iack_n = 1'b1;
      step();
      chk("R9", "vec_oe in release", 32'(vec_oe), 32'd0);
      chk("R9", "dtack_oe in release", 32'(dtack_oe), 32'd1);
      chk("R9", "dtack_n in release", 32'(dtack_n), 32'd1);
      step();
      chk("R9", "dtack_oe after release", 32'(dtack_oe), 32'd0);

      // R3 late request not served in current acknowledge
      do_reset();
      pulse_req(4'b0100);
      iack_n = 1'b0;
      step();
      src_req = 4'b0001;
      step();
      src_req = '0;
      chk("R3", "frozen winner", 32'(vec), 32'(vec_of(2)));
      iack_n = 1'b1;
      step();
      step();
      chk("R3", "late request pending", 32'(intr_n), 32'd0);
      served_ack("R3", 0);
      chk("R3", "all served", 32'(intr_n), 32'd1);

      // R10 repeated service in priority order
      do_reset();
      pulse_req(4'b1011);
      served_ack("R10", 0);
      chk("R10", "intr_n again", 32'(intr_n), 32'd0);
      served_ack("R10", 1);
      served_ack("R10", 3);
      chk("R10", "intr_n idle", 32'(intr_n), 32'd1);

      // R2 independent of iei_n; disabled source holds its request
      do_reset();
      iei_n  = 1'b1;
      src_en = 4'b1011;
      pulse_req(4'b0100);
      chk("R2", "disabled source", 32'(intr_n), 32'd1);
      src_en = '1;
      #1;
      chk("R2", "enabled later, iei_n high", 32'(intr_n), 32'd0);

      // R8 iei_n high: no answer; R6 immediate ieo_n release
      iack_n = 1'b0;
      step();
      step();
      chk("R8", "no drive with iei_n high", 32'(vec_oe | dtack_oe), 32'd0);
      iack_n = 1'b1;
      step();
      step();
      do_reset();
      iack_n = 1'b0;
      step();
      chk("R6", "ieo_n low when empty", 32'(ieo_n), 32'd0);
      iei_n = 1'b1;
      #1;
      chk("R6", "ieo_n forced by iei_n", 32'(ieo_n), 32'd1);
      iei_n = 1'b0;
      #1;
      iack_n = 1'b1;
      #1;
      chk("R6", "ieo_n forced by iack_n", 32'(ieo_n), 32'd1);
      step();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule